// File: doc/BRIEF.md
# Exception Restart-Address Capture and Return Unit

This unit sits beside a processor's control state and handles the program-counter side of taking and leaving an exception. When an event strobe arrives, it computes the address at which execution must later resume. It stores that address in the save register that belongs to the event class and updates the status and cause fields. It then steers the next PC to the handler entry. When a return strobe arrives, it restores the PC and the instruction-set mode from the matching save register and releases the status level that the handler was running under.

The processor mixes 32-bit and compressed 16-bit instructions. Bit 0 of every saved restart address therefore records the mode that was active, and bit 0 of every restored address supplies the mode again. Handlers always start in 32-bit mode. An instruction that faults in a branch delay slot restarts at its branch. Because that branch may be 2 or 4 bytes long, the rewind distance depends on the branch width.

All state changes happen on one rising clock edge, the edge at which a strobe is sampled. A new PC is reported on the following cycle through a one-cycle load pulse. The same timing applies to the request to clear the pipeline's delay-slot flag.

Top module: `exc_pc_unit`

## Requirements
- R1: The restart address is `cur_pc` with `cur_isa` placed in bit 0. When `in_dslot` is 1, the address is reduced by 2 if `br16` is 1 and by 4 if `br16` is 0.
- R2: A general event (`evt_kind` = 0) taken while `exl` is 0 writes the restart address to `epc`, copies `in_dslot` to `cause_bd` and sets `exl`.
- R3: A general event taken while `exl` is 1 leaves `epc` and `cause_bd` unchanged, and `exl` stays 1.
- R4: Every general event writes `cause_code` into `cause_exc`. It also sets `next_pc` to `ebase` with its low 10 bits cleared, plus `vec_offset`.
- R5: An error event (`evt_kind` = 1) writes the restart address to `errorepc`, sets `erl` and `bev`, and sets `next_pc` to 0xBFC00000.
- R6: A debug event (`evt_kind` = 2 or 3) writes the restart address to `depc` and sets `next_pc` to 0xBFC00480.
- R7: After any event, `isa_mode` is 0, and `pc_load` and `dslot_clr` are 1 for exactly the following cycle.
- R8: An exception return (`ret_valid` with `ret_debug` = 0) taken while `erl` is 1 restores from `errorepc` and clears `erl`; `exl` is left unchanged.
- R9: An exception return taken while `erl` is 0 restores from `epc` and clears `exl`.
- R10: A debug return (`ret_debug` = 1) restores from `depc` and leaves `exl`, `erl` and `bev` unchanged.
- R11: On every return, `next_pc` is the saved value with bit 0 cleared, `isa_mode` takes bit 0 of the saved value, and `pc_load` pulses while `dslot_clr` stays 0.
- R12: When an event and a return are strobed in the same cycle, only the event is performed.
- R13: While `rst_n` is 0 at a clock edge, every register output, including `exl`, `erl`, `bev`, `isa_mode`, `pc_load` and `dslot_clr`, becomes 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_valid | input | 1 | Take an event this cycle |
| evt_kind | input | 2 | 0 general, 1 error (reset/NMI), 2 or 3 debug |
| ret_valid | input | 1 | Execute a return this cycle |
| ret_debug | input | 1 | 1 selects debug return, 0 exception return |
| cur_pc | input | XLEN | PC of the faulting instruction |
| cur_isa | input | 1 | Current mode, 1 = compressed |
| in_dslot | input | 1 | Instruction sits in a branch delay slot |
| br16 | input | 1 | The owning branch is a 16-bit instruction |
| cause_code | input | CAUSE_W | Exception code for general events |
| ebase | input | XLEN | Exception base register |
| vec_offset | input | OFF_W | Offset added to the masked base |
| epc | output | XLEN | General exception save register |
| errorepc | output | XLEN | Error save register |
| depc | output | XLEN | Debug save register |
| exl | output | 1 | Exception level |
| erl | output | 1 | Error level |
| bev | output | 1 | Boot vector select |
| cause_bd | output | 1 | Cause delay-slot bit |
| cause_exc | output | CAUSE_W | Cause exception code |
| next_pc | output | XLEN | PC to load |
| isa_mode | output | 1 | Current instruction-set mode |
| pc_load | output | 1 | `next_pc` is valid this cycle |
| dslot_clr | output | 1 | Clear the pipeline delay-slot flag |

## Verification
The bench builds the unit with its default parameters: a 32-bit datapath, a 5-bit cause code, a 12-bit vector offset and a 10-bit base alignment. These widths place the restart rewind across a 4 KiB page boundary within reach of the directed cases. They also let random base and offset values produce carries out of the masked base. Random strobes are biased so that nested general events arrive while `exl` is set. Error events leave `erl` set often enough that exception returns take both save-register paths. Collisions of an event with a return occur many times per run.

// File: rtl/exc_pc_pkg.sv
// Package: shared event encodings for the exception PC unit.
// Assumes evt_kind is two bits wide; both codes with bit 1 set mean debug.
package exc_pc_pkg;

    typedef enum logic [1:0] {
        EK_GENERAL = 2'd0,
        EK_ERROR   = 2'd1,
        EK_DEBUG   = 2'd2,
        EK_DEBUG_B = 2'd3
    } evt_kind_e;

    localparam logic [31:0] ERROR_VECTOR = 32'hBFC0_0000;
    localparam logic [31:0] DEBUG_VECTOR = 32'hBFC0_0480;

    // True when the event class enters the debug handler.
    function automatic logic kind_is_debug(input logic [1:0] k);
        return k[1];
    endfunction

endpackage

// File: rtl/exc_resume_calc.sv
// Module: exc_resume_calc
// Computes the restart address for an event. The mode bit is merged into
// bit 0. A delay-slot fault is rewound by the width of its branch.
// Assumes cur_pc bit 0 is zero whenever cur_isa is 1 (halfword aligned).
module exc_resume_calc #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] cur_pc,
    input  logic            cur_isa,
    input  logic            in_dslot,
    input  logic            br16,
    output logic [XLEN-1:0] resume
);

    localparam logic [XLEN-1:0] REWIND_NARROW = XLEN'(2);
    localparam logic [XLEN-1:0] REWIND_WIDE   = XLEN'(4);

    logic [XLEN-1:0] tagged_pc;
    logic [XLEN-1:0] rewind;

    // Merge the mode bit into the low address bit.
    always_comb begin
        tagged_pc = cur_pc | {{(XLEN-1){1'b0}}, cur_isa};
    end

    // Select the rewind distance from the branch width.
    always_comb begin
        if (!in_dslot) begin
            rewind = '0;
        end else if (br16) begin
            rewind = REWIND_NARROW;
        end else begin
            rewind = REWIND_WIDE;
        end
    end

    // Final restart address.
    always_comb begin
        resume = tagged_pc - rewind;
    end

endmodule

// File: rtl/exc_vector_sel.sv
// Module: exc_vector_sel
// Chooses the handler entry address for an event class. General events use
// the base register, aligned to 2**VEC_ALIGN, plus an offset. Error and
// debug events use fixed addresses. Assumes XLEN >= 32.
module exc_vector_sel
    import exc_pc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int OFF_W     = 12,
    parameter int VEC_ALIGN = 10
) (
    input  logic [1:0]      evt_kind,
    input  logic [XLEN-1:0] ebase,
    input  logic [OFF_W-1:0] vec_offset,
    output logic [XLEN-1:0] vector
);

    localparam logic [XLEN-1:0] ERR_V = XLEN'($signed(ERROR_VECTOR));
    localparam logic [XLEN-1:0] DBG_V = XLEN'($signed(DEBUG_VECTOR));

    logic [XLEN-1:0] base_aligned;
    logic [XLEN-1:0] general_vec;

    // Strip the alignment bits from the base; no masking when alignment is 0.
    generate
        if (VEC_ALIGN == 0) begin : g_no_align
            always_comb base_aligned = ebase;
        end else begin : g_align
            localparam logic [XLEN-1:0] LOW_MASK = (XLEN'(1) << VEC_ALIGN) - XLEN'(1);
            always_comb base_aligned = ebase & ~LOW_MASK;
        end
    endgenerate

    // General entry is the aligned base plus the offset.
    always_comb begin
        general_vec = base_aligned + XLEN'(vec_offset);
    end

    // Pick the entry for the event class.
    always_comb begin
        if (kind_is_debug(evt_kind)) begin
            vector = DBG_V;
        end else if (evt_kind == EK_ERROR) begin
            vector = ERR_V;
        end else begin
            vector = general_vec;
        end
    end

endmodule

// File: rtl/exc_ret_decode.sv
// Module: exc_ret_decode
// Picks the save register for a return command, then splits it into an
// even PC and a mode bit. It also says which status level to release.
// Assumes it is consulted only when a return is being executed.
module exc_ret_decode #(
    parameter int XLEN = 32
) (
    input  logic            ret_debug,
    input  logic            erl,
    input  logic [XLEN-1:0] epc,
    input  logic [XLEN-1:0] errorepc,
    input  logic [XLEN-1:0] depc,
    output logic [XLEN-1:0] ret_pc,
    output logic            ret_isa,
    output logic            drop_erl,
    output logic            drop_exl
);

    logic [XLEN-1:0] saved;

    // Save-register selection; the error level shadows the exception level.
    always_comb begin
        drop_erl = 1'b0;
        drop_exl = 1'b0;
        if (ret_debug) begin
            saved = depc;
        end else if (erl) begin
            saved    = errorepc;
            drop_erl = 1'b1;
        end else begin
            saved    = epc;
            drop_exl = 1'b1;
        end
    end

    // Split the saved word into address and mode.
    always_comb begin
        ret_pc  = {saved[XLEN-1:1], 1'b0};
        ret_isa = saved[0];
    end

endmodule

// File: rtl/exc_pc_unit.sv
// Module: exc_pc_unit (top)
// Captures restart addresses on events and restores PC and mode on returns.
// Every update lands on the edge where a strobe is sampled. An event wins
// over a return in the same cycle. Reset is synchronous and active low.
module exc_pc_unit
    import exc_pc_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int CAUSE_W   = 5,
    parameter int OFF_W     = 12,
    parameter int VEC_ALIGN = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               evt_valid,
    input  logic [1:0]         evt_kind,
    input  logic               ret_valid,
    input  logic               ret_debug,
    input  logic [XLEN-1:0]    cur_pc,
    input  logic               cur_isa,
    input  logic               in_dslot,
    input  logic               br16,
    input  logic [CAUSE_W-1:0] cause_code,
    input  logic [XLEN-1:0]    ebase,
    input  logic [OFF_W-1:0]   vec_offset,
    output logic [XLEN-1:0]    epc,
    output logic [XLEN-1:0]    errorepc,
    output logic [XLEN-1:0]    depc,
    output logic               exl,
    output logic               erl,
    output logic               bev,
    output logic               cause_bd,
    output logic [CAUSE_W-1:0] cause_exc,
    output logic [XLEN-1:0]    next_pc,
    output logic               isa_mode,
    output logic               pc_load,
    output logic               dslot_clr
);

    logic [XLEN-1:0] resume;
    logic [XLEN-1:0] vector;
    logic [XLEN-1:0] ret_pc;
    logic            ret_isa;
    logic            drop_erl;
    logic            drop_exl;
    logic            take_ret;

    exc_resume_calc #(.XLEN(XLEN)) u_resume (
        .cur_pc   (cur_pc),
        .cur_isa  (cur_isa),
        .in_dslot (in_dslot),
        .br16     (br16),
        .resume   (resume)
    );

    exc_vector_sel #(.XLEN(XLEN), .OFF_W(OFF_W), .VEC_ALIGN(VEC_ALIGN)) u_vector (
        .evt_kind   (evt_kind),
        .ebase      (ebase),
        .vec_offset (vec_offset),
        .vector     (vector)
    );

    exc_ret_decode #(.XLEN(XLEN)) u_ret (
        .ret_debug (ret_debug),
        .erl       (erl),
        .epc       (epc),
        .errorepc  (errorepc),
        .depc      (depc),
        .ret_pc    (ret_pc),
        .ret_isa   (ret_isa),
        .drop_erl  (drop_erl),
        .drop_exl  (drop_exl)
    );

    // A return is honoured only when no event claims the cycle.
    always_comb begin
        take_ret = ret_valid && !evt_valid;
    end

    // Save registers, status and cause fields, next PC and mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            epc       <= '0;
            errorepc  <= '0;
            depc      <= '0;
            exl       <= 1'b0;
            erl       <= 1'b0;
            bev       <= 1'b0;
            cause_bd  <= 1'b0;
            cause_exc <= '0;
            next_pc   <= '0;
            isa_mode  <= 1'b0;
            pc_load   <= 1'b0;
            dslot_clr <= 1'b0;
        end else begin
            pc_load   <= 1'b0;
            dslot_clr <= 1'b0;
            if (evt_valid) begin
                pc_load   <= 1'b1;
                dslot_clr <= 1'b1;
                next_pc   <= vector;
                isa_mode  <= 1'b0;
                if (kind_is_debug(evt_kind)) begin
                    depc <= resume;
                end else if (evt_kind == EK_ERROR) begin
                    errorepc <= resume;
                    erl      <= 1'b1;
                    bev      <= 1'b1;
                end else begin
                    cause_exc <= cause_code;
                    if (!exl) begin
                        epc      <= resume;
                        cause_bd <= in_dslot;
                        exl      <= 1'b1;
                    end
                end
            end else if (take_ret) begin
                pc_load  <= 1'b1;
                next_pc  <= ret_pc;
                isa_mode <= ret_isa;
                if (drop_erl) erl <= 1'b0;
                if (drop_exl) exl <= 1'b0;
            end
        end
    end

    // ---------------- assertions guarding the update logic ----------------

    // A general event always leaves the exception level set.
    assert_gen_sets_exl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EK_GENERAL) |=> exl);

    // A nested general event does not disturb the saved address or BD.
    assert_nested_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EK_GENERAL && exl) |=> ($stable(epc) && $stable(cause_bd)));

    // An error event raises the error level and the boot vector bit.
    assert_err_sets_erl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_kind == EK_ERROR) |=> (erl && bev));

    // Handlers always start in 32-bit mode with both pulses raised.
    assert_event_mode_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |=> (!isa_mode && pc_load && dslot_clr));

    // A return under the error level releases only that level.
    assert_eret_erl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !evt_valid && !ret_debug && erl) |=> (!erl && $stable(exl)));

    // A debug return does not touch the status levels.
    assert_deret_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !evt_valid && ret_debug) |=> ($stable(exl) && $stable(erl) && $stable(bev)));

    // A returned PC is always even and the delay-slot clear stays low.
    assert_ret_even_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && !evt_valid) |=> (!next_pc[0] && pc_load && !dslot_clr));

    // A colliding return never lowers a status level.
    assert_collision_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && ret_valid) |=> (!$fell(exl) && !$fell(erl)));

endmodule

// File: tb/test_exc_pc_unit.sv
`timescale 1ns/1ps
module test_exc_pc_unit;

    localparam int XLEN = 32;
    localparam int CW   = 5;
    localparam int OW   = 12;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            evt_valid;
    logic [1:0]      evt_kind;
    logic            ret_valid;
    logic            ret_debug;
    logic [XLEN-1:0] cur_pc;
    logic            cur_isa;
    logic            in_dslot;
    logic            br16;
    logic [CW-1:0]   cause_code;
    logic [XLEN-1:0] ebase;
    logic [OW-1:0]   vec_offset;
    logic [XLEN-1:0] epc, errorepc, depc, next_pc;
    logic            exl, erl, bev, cause_bd, isa_mode, pc_load, dslot_clr;
    logic [CW-1:0]   cause_exc;

    always #2.5 clk = ~clk;

    exc_pc_unit i_exc_pc_unit (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .ret_valid(ret_valid), .ret_debug(ret_debug), .cur_pc(cur_pc),
        .cur_isa(cur_isa), .in_dslot(in_dslot), .br16(br16),
        .cause_code(cause_code), .ebase(ebase), .vec_offset(vec_offset),
        .epc(epc), .errorepc(errorepc), .depc(depc), .exl(exl), .erl(erl),
        .bev(bev), .cause_bd(cause_bd), .cause_exc(cause_exc),
        .next_pc(next_pc), .isa_mode(isa_mode), .pc_load(pc_load),
        .dslot_clr(dslot_clr)
    );

    // Reference state kept by the bench.
    logic [XLEN-1:0] m_epc, m_errorepc, m_depc, m_next_pc;
    logic            m_exl, m_erl, m_bev, m_bd, m_isa, m_load, m_dclr;
    logic [CW-1:0]   m_exc;
    string           m_tag;

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // Restart address per R1.
    function automatic logic [XLEN-1:0] f_resume(input logic [XLEN-1:0] pc,
            input logic isa, input logic ds, input logic b16);
        logic [XLEN-1:0] a;
        a = {pc[XLEN-1:1], pc[0] | isa};
        if (ds) a = a - (b16 ? 32'd2 : 32'd4);
        return a;
    endfunction

    // General entry address per R4.
    function automatic logic [XLEN-1:0] f_gen_vec(input logic [XLEN-1:0] b,
            input logic [OW-1:0] off);
        return {b[XLEN-1:10], 10'd0} + {20'd0, off};
    endfunction

    task automatic model_reset();
        m_epc = '0; m_errorepc = '0; m_depc = '0; m_next_pc = '0;
        m_exl = 0; m_erl = 0; m_bev = 0; m_bd = 0; m_isa = 0;
        m_load = 0; m_dclr = 0; m_exc = '0;
    endtask

    // Apply one clock of behaviour to the reference state and pick the tag.
    task automatic model_step();
        logic [XLEN-1:0] r;
        logic [XLEN-1:0] s;
        r = f_resume(cur_pc, cur_isa, in_dslot, br16);
        m_load = 0; m_dclr = 0;
        if (evt_valid) begin
            m_load = 1; m_dclr = 1; m_isa = 0;
            m_tag = ret_valid ? "R12" : "R7";
            if (evt_kind[1]) begin
                m_depc = r; m_next_pc = 32'hBFC0_0480;
                if (!ret_valid) m_tag = "R6";
            end else if (evt_kind == 2'd1) begin
                m_errorepc = r; m_erl = 1; m_bev = 1; m_next_pc = 32'hBFC0_0000;
                if (!ret_valid) m_tag = "R5";
            end else begin
                m_exc = cause_code; m_next_pc = f_gen_vec(ebase, vec_offset);
                if (!m_exl) begin
                    m_epc = r; m_bd = in_dslot; m_exl = 1;
                    if (!ret_valid) m_tag = in_dslot ? "R1" : "R2";
                end else if (!ret_valid) m_tag = "R3";
            end
        end else if (ret_valid) begin
            m_load = 1;
            if (ret_debug) begin
                s = m_depc; m_tag = "R10";
            end else if (m_erl) begin
                s = m_errorepc; m_erl = 0; m_tag = "R8";
            end else begin
                s = m_epc; m_exl = 0; m_tag = "R9";
            end
            m_next_pc = {s[XLEN-1:1], 1'b0};
            m_isa = s[0];
        end else begin
            m_tag = "R11";
        end
    endtask

    task automatic chk(input string tag, input string what,
            input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // Compare every output against the reference; counts as one vector.
    task automatic compare_all();
        vectors++;
        chk(m_tag, "epc",       epc,       m_epc);
        chk(m_tag, "errorepc",  errorepc,  m_errorepc);
        chk(m_tag, "depc",      depc,      m_depc);
        chk(m_tag, "exl",       {31'd0, exl},       {31'd0, m_exl});
        chk(m_tag, "erl",       {31'd0, erl},       {31'd0, m_erl});
        chk(m_tag, "bev",       {31'd0, bev},       {31'd0, m_bev});
        chk(m_tag, "cause_bd",  {31'd0, cause_bd},  {31'd0, m_bd});
        chk("R4",  "cause_exc", {27'd0, cause_exc}, {27'd0, m_exc});
        chk(m_tag, "next_pc",   next_pc,   m_next_pc);
        chk(m_tag, "isa_mode",  {31'd0, isa_mode},  {31'd0, m_isa});
        chk(m_tag, "pc_load",   {31'd0, pc_load},   {31'd0, m_load});
        chk(m_tag, "dslot_clr", {31'd0, dslot_clr}, {31'd0, m_dclr});
    endtask

    task automatic idle_inputs();
        evt_valid = 0; evt_kind = 0; ret_valid = 0; ret_debug = 0;
        cur_pc = '0; cur_isa = 0; in_dslot = 0; br16 = 0;
        cause_code = '0; ebase = '0; vec_offset = '0;
    endtask

    // Inputs are already driven at a falling edge; advance one cycle and check.
    task automatic step();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare_all();
    endtask

    task automatic drive_evt(input logic [1:0] k, input logic [XLEN-1:0] pc,
            input logic isa, input logic ds, input logic b16);
        idle_inputs();
        evt_valid = 1; evt_kind = k; cur_pc = pc; cur_isa = isa;
        in_dslot = ds; br16 = b16; cause_code = 5'd12;
        ebase = 32'h8000_13FF; vec_offset = 12'h180;
        step();
    endtask

    task automatic drive_ret(input logic dbg);
        idle_inputs();
        ret_valid = 1; ret_debug = dbg;
        step();
    endtask

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        rst_n = 0;
        model_reset();
        repeat (3) @(negedge clk);
        m_tag = "R13";
        compare_all();
        rst_n = 1;
        idle_inputs(); step();

        // R1: compressed mode, 16-bit branch, rewind across a page boundary.
        drive_evt(2'd0, 32'h8000_1000, 1'b1, 1'b1, 1'b1);
        drive_ret(1'b0);                               // R9 restores mode 1
        // R1: 32-bit branch rewind.
        drive_evt(2'd0, 32'h8000_2000, 1'b0, 1'b1, 1'b0);
        // R3: nested general event keeps EPC.
        drive_evt(2'd0, 32'h8000_3000, 1'b0, 1'b0, 1'b0);
        // R5 then R8: error over exception level.
        drive_evt(2'd1, 32'h8000_4002, 1'b1, 1'b0, 1'b0);
        drive_ret(1'b0);
        drive_ret(1'b0);
        // R6 then R10.
        drive_evt(2'd3, 32'h8000_5004, 1'b1, 1'b1, 1'b1);
        drive_ret(1'b1);
        // R12: collision of event and return.
        idle_inputs();
        evt_valid = 1; evt_kind = 2'd1; ret_valid = 1; cur_pc = 32'h9000_0010;
        step();
        // Soft reset mid-run, R13.
        idle_inputs(); rst_n = 0;
        @(posedge clk); model_reset(); @(negedge clk);
        m_tag = "R13"; compare_all();
        rst_n = 1;

        // Random phase.
        for (int i = 0; i < 4000; i++) begin
            idle_inputs();
            evt_valid  = ($urandom_range(0, 99) < 35);
            evt_kind   = 2'($urandom_range(0, 3));
            ret_valid  = ($urandom_range(0, 99) < 35);
            ret_debug  = ($urandom_range(0, 3) == 0);
            cur_pc     = $urandom() & 32'hFFFF_FFFE;
            cur_isa    = 1'($urandom());
            in_dslot   = 1'($urandom());
            br16       = 1'($urandom());
            cause_code = 5'($urandom());
            ebase      = $urandom();
            vec_offset = 12'($urandom());
            step();
        end

        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule